// File: doc/BRIEF.md
# Dual-Bus Program Fetch Steering Controller

This block runs the external code-fetch sequence of an 8-bit controller that can read its program from either of two buses. The primary bus multiplexes the low address byte with data on one port, carries the high address byte on a second port, and has its own active-low read strobe. The auxiliary bus is a pair of 8-bit ports with the same layout and a separate active-low strobe. One address-latch enable line serves both buses. Two mode pins, latched while reset is held, select the primary bus only, the auxiliary bus only, or a split in which the low 8 KB of code is read from the auxiliary bus. One of the four pin combinations is illegal and is flagged.

Each 12-clock machine cycle holds two 6-clock fetch windows. In each window the block latches the fetch address, pulses ALE, puts out the address bytes, releases the low port, pulses the chosen strobe, and captures the opcode byte when the strobe rises. When the core reports an external data access for the cycle, the second window does no fetch, so the data transfer can use the primary bus.

Top module: `fetch_steer_top`

## Requirements
- R1: While `rst_n` is low, both strobes are high, `ale` is low, every output-enable is low, every address output is 0 and `opcode_valid` is low.
- R2: A machine cycle is 12 clocks and holds two 6-clock windows. The first clock after reset release is window position 0. In a live window `ale` is high at positions 0 and 1, and the selected strobe is low at positions 3 and 4 only.
- R3: With `bus_sel_pin`=0 and `ext_fetch_pin`=0 latched, every fetch in 0000h–FFFFh uses the primary bus and `pri_strobe_n`, and `aux_strobe_n` stays high.
- R4: With `bus_sel_pin`=0 and `ext_fetch_pin`=1 latched, `mode_invalid` is 1 and no fetch takes place: no `ale`, both strobes high, no output-enable asserted.
- R5: With `bus_sel_pin`=1 and `ext_fetch_pin`=0 latched, every fetch in 0000h–FFFFh uses the auxiliary bus and `aux_strobe_n`, and `pri_strobe_n` stays high.
- R6: With both pins 1 latched, addresses below 2000h are fetched on the auxiliary bus, and addresses 2000h and above on the primary bus.
- R7: `fetch_addr` is sampled on the last clock (position 5) of the window before. On the selected bus the high byte is driven with its enable high for all six positions. The low byte is driven, with its enable high, at positions 0 to 2 and released at positions 3 to 5. An address output with a low enable reads 0.
- R8: `xdata_pending`, sampled on the last clock of the first window, makes the second window of that cycle idle: no `ale`, no strobe, no drive, no opcode.
- R9: On the clock edge that ends position 4 of a live window, the low-port input of the selected bus is stored in `opcode`, and `opcode_valid` is high for exactly the one clock that follows.
- R10: When `bus_sel_pin` was latched low, `aux_lo_oe` and `aux_hi_oe` stay low and the auxiliary address outputs read 0.
- R11: Mode pins are sampled only while `rst_n` is low. Changing them after release has no effect on routing or on `mode_invalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset; mode pins are latched while low |
| bus_sel_pin | input | 1 | Mode pin: enables the auxiliary code bus |
| ext_fetch_pin | input | 1 | Mode pin: external-access select |
| fetch_addr | input | 16 | Code address of the next window |
| xdata_pending | input | 1 | External data access in this cycle's second window |
| pri_ad_in | input | 8 | Primary low port read data |
| aux_lo_in | input | 8 | Auxiliary low port read data |
| ale | output | 1 | Address-latch enable (shared) |
| pri_ad_out | output | 8 | Primary low port address byte |
| pri_ad_oe | output | 1 | Primary low port drive enable |
| pri_hi_out | output | 8 | Primary high address byte |
| pri_hi_oe | output | 1 | Primary high port drive enable |
| pri_strobe_n | output | 1 | Primary fetch strobe, active low |
| aux_lo_out | output | 8 | Auxiliary low port address byte |
| aux_lo_oe | output | 1 | Auxiliary low port drive enable |
| aux_hi_out | output | 8 | Auxiliary high address byte |
| aux_hi_oe | output | 1 | Auxiliary high port drive enable |
| aux_strobe_n | output | 1 | Auxiliary fetch strobe, active low |
| opcode | output | 8 | Last captured opcode byte |
| opcode_valid | output | 1 | One-clock pulse after a capture |
| mode_invalid | output | 1 | Latched mode pins form the illegal combination |

## Verification
The assertions check, on every cycle, the rules that hold whatever the address. The two strobes are never low together. `ale` never overlaps a strobe. An illegal mode keeps the bus silent. The auxiliary enables stay low when that bus is off. The window counter stays in range. `opcode_valid` only follows a strobe. The latched mode cannot change after release. Only the bench's scenarios show the address-dependent routing at the 1FFFh/2000h boundary, the second-window skip and the opcode byte taken from the right port. The same goes for the byte placement on each port and for pin changes after release being ignored. The bench compares every output, every clock, against its own cycle model in all four modes.

// File: rtl/fetch_steer_pkg.sv
// Package: shared mode encoding and the routing rule for the fetch steering
// controller. Assumes a 16-bit code address space.
package fetch_steer_pkg;

    // Latched mode pins, {bus_sel, ext_fetch}.
    typedef enum logic [1:0] {
        MODE_PRIMARY = 2'b00,
        MODE_INVALID = 2'b01,
        MODE_AUX     = 2'b10,
        MODE_SPLIT   = 2'b11
    } fetch_mode_e;

    localparam int BUS_PRI = 0;
    localparam int BUS_AUX = 1;
    localparam int NUM_BUS = 2;

    // Returns 1 when the address is fetched over the auxiliary bus.
    function automatic logic route_to_aux(fetch_mode_e mode, logic [15:0] addr,
                                          logic [15:0] split_base);
        case (mode)
            MODE_AUX:   return 1'b1;
            MODE_SPLIT: return (addr < split_base);
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fs_cycle_timer.sv
// Module: fs_cycle_timer
// Splits each machine cycle into two fetch windows of WIN_LEN clocks and
// reports the window position and which half is running.
// Assumes: the position leaves reset on the last clock of the second half, so
// the first clock after release is position 0 of a new cycle.
module fs_cycle_timer #(
    parameter int WIN_LEN = 6,
    localparam int POS_W  = $clog2(WIN_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [POS_W-1:0] pos,
    output logic             second_half,
    output logic             win_last
);

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(WIN_LEN - 1);

    // Advances the position inside a window and swaps halves at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos         <= POS_LAST;
            second_half <= 1'b1;
        end else if (pos == POS_LAST) begin
            pos         <= '0;
            second_half <= ~second_half;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    // Marks the final clock of the current window.
    always_comb win_last = (pos == POS_LAST);

    a_r2_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= POS_LAST);
    a_r2_half_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && $past(win_last)) |-> (second_half != $past(second_half)));

endmodule

// File: rtl/fs_mode_latch.sv
// Module: fs_mode_latch
// Holds the two mode pins as they stand while reset is asserted. They are
// frozen at release, so the bus choice never moves mid-cycle.
// Assumes: the pins are settled during reset.
module fs_mode_latch
    import fetch_steer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel_pin,
    input  logic        ext_fetch_pin,
    output fetch_mode_e mode,
    output logic        aux_enabled,
    output logic        invalid
);

    // Samples the pins only while reset is held low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= fetch_mode_e'({bus_sel_pin, ext_fetch_pin});
        end
    end

    // Decodes the latched mode into the two flags used downstream.
    always_comb begin
        aux_enabled = (mode == MODE_AUX) || (mode == MODE_SPLIT);
        invalid     = (mode == MODE_INVALID);
    end

    a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode));

endmodule

// File: rtl/fs_window_sel.sv
// Module: fs_window_sel
// At the end of each window, loads the address for the next window, picks its
// bus and decides whether that window fetches at all.
// Assumes: xdata_pending is meaningful on the last clock of the first half.
module fs_window_sel
    import fetch_steer_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] SPLIT_BASE = 16'h2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fetch_mode_e       mode,
    input  logic              invalid,
    input  logic              win_last,
    input  logic              second_half,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              xdata_pending,
    output logic [ADDR_W-1:0] win_addr,
    output logic              win_aux,
    output logic              win_live
);

    logic skip_next;

    // The next window is the second half when the first half is ending.
    always_comb skip_next = !second_half && xdata_pending;

    // Loads the next window's address, route and live flag at window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_addr <= '0;
            win_aux  <= 1'b0;
            win_live <= 1'b0;
        end else if (win_last) begin
            win_addr <= fetch_addr;
            win_aux  <= route_to_aux(mode, 16'(fetch_addr), SPLIT_BASE);
            win_live <= !invalid && !skip_next;
        end
    end

    a_r4_invalid_never_live: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> !win_live);
    a_r3_primary_mode_no_aux: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PRIMARY) |-> !win_aux);

endmodule

// File: rtl/fs_bus_driver.sv
// Module: fs_bus_driver
// Drives one code bus through a fetch window: address phase, then read strobe,
// then a capture request on the strobe's last low clock.
// Assumes: sel is constant across the window; both buses use the same timing.
module fs_bus_driver #(
    parameter int WIN_LEN   = 6,
    parameter int ALE_CLKS  = 2,
    parameter int ADDR_CLKS = 3,
    parameter int STB_FIRST = 3,
    parameter int STB_LAST  = 4,
    localparam int POS_W    = $clog2(WIN_LEN)
) (
    input  logic             sel,
    input  logic [POS_W-1:0] pos,
    input  logic [15:0]      addr,
    output logic             ale_req,
    output logic [7:0]       lo_out,
    output logic             lo_oe,
    output logic [7:0]       hi_out,
    output logic             hi_oe,
    output logic             strobe_n,
    output logic             capture
);

    localparam logic [POS_W-1:0] P_ALE_END  = POS_W'(ALE_CLKS);
    localparam logic [POS_W-1:0] P_ADDR_END = POS_W'(ADDR_CLKS);
    localparam logic [POS_W-1:0] P_STB_A    = POS_W'(STB_FIRST);
    localparam logic [POS_W-1:0] P_STB_B    = POS_W'(STB_LAST);

    // Window phase decode for this bus.
    always_comb begin
        ale_req  = sel && (pos < P_ALE_END);
        lo_oe    = sel && (pos < P_ADDR_END);
        lo_out   = lo_oe ? addr[7:0] : 8'h00;
        hi_oe    = sel;
        hi_out   = sel ? addr[15:8] : 8'h00;
        strobe_n = !(sel && (pos >= P_STB_A) && (pos <= P_STB_B));
        capture  = sel && (pos == P_STB_B);
    end

endmodule

// File: rtl/fetch_steer_top.sv
// Module: fetch_steer_top
// External code-fetch sequencer steering each fetch window to the primary or
// auxiliary bus from latched mode pins and the fetch address, and capturing
// the opcode byte as the strobe rises.
// Assumes: fetch_addr is valid on the last clock of the window before.
module fetch_steer_top
    import fetch_steer_pkg::*;
#(
    parameter int          WIN_LEN    = 6,
    parameter int          ALE_CLKS   = 2,
    parameter int          ADDR_CLKS  = 3,
    parameter int          STB_FIRST  = 3,
    parameter int          STB_LAST   = 4,
    parameter logic [15:0] SPLIT_BASE = 16'h2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel_pin,
    input  logic        ext_fetch_pin,
    input  logic [15:0] fetch_addr,
    input  logic        xdata_pending,
    input  logic [7:0]  pri_ad_in,
    input  logic [7:0]  aux_lo_in,
    output logic        ale,
    output logic [7:0]  pri_ad_out,
    output logic        pri_ad_oe,
    output logic [7:0]  pri_hi_out,
    output logic        pri_hi_oe,
    output logic        pri_strobe_n,
    output logic [7:0]  aux_lo_out,
    output logic        aux_lo_oe,
    output logic [7:0]  aux_hi_out,
    output logic        aux_hi_oe,
    output logic        aux_strobe_n,
    output logic [7:0]  opcode,
    output logic        opcode_valid,
    output logic        mode_invalid
);

    localparam int POS_W = $clog2(WIN_LEN);

    logic [POS_W-1:0] pos;
    logic             second_half;
    logic             win_last;
    fetch_mode_e      mode;
    logic             aux_enabled;
    logic [15:0]      win_addr;
    logic             win_aux;
    logic             win_live;

    logic [NUM_BUS-1:0] bus_sel;
    logic [NUM_BUS-1:0] bus_ale;
    logic [NUM_BUS-1:0] bus_lo_oe;
    logic [NUM_BUS-1:0] bus_hi_oe;
    logic [NUM_BUS-1:0] bus_stb_n;
    logic [NUM_BUS-1:0] bus_cap;
    logic [7:0]         bus_lo_out [NUM_BUS];
    logic [7:0]         bus_hi_out [NUM_BUS];
    logic [7:0]         bus_rd     [NUM_BUS];

    fs_cycle_timer #(.WIN_LEN(WIN_LEN)) timer_i (
        .clk(clk), .rst_n(rst_n), .pos(pos),
        .second_half(second_half), .win_last(win_last)
    );

    fs_mode_latch mode_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_pin(bus_sel_pin),
        .ext_fetch_pin(ext_fetch_pin), .mode(mode),
        .aux_enabled(aux_enabled), .invalid(mode_invalid)
    );

    fs_window_sel #(.ADDR_W(16), .SPLIT_BASE(SPLIT_BASE)) win_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .invalid(mode_invalid),
        .win_last(win_last), .second_half(second_half),
        .fetch_addr(fetch_addr), .xdata_pending(xdata_pending),
        .win_addr(win_addr), .win_aux(win_aux), .win_live(win_live)
    );

    // Per-bus selection and read data.
    always_comb begin
        bus_sel[BUS_PRI] = win_live && !win_aux;
        bus_sel[BUS_AUX] = win_live && win_aux && aux_enabled;
        bus_rd[BUS_PRI]  = pri_ad_in;
        bus_rd[BUS_AUX]  = aux_lo_in;
    end

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        fs_bus_driver #(
            .WIN_LEN(WIN_LEN), .ALE_CLKS(ALE_CLKS), .ADDR_CLKS(ADDR_CLKS),
            .STB_FIRST(STB_FIRST), .STB_LAST(STB_LAST)
        ) drv_i (
            .sel(bus_sel[b]), .pos(pos), .addr(win_addr),
            .ale_req(bus_ale[b]), .lo_out(bus_lo_out[b]), .lo_oe(bus_lo_oe[b]),
            .hi_out(bus_hi_out[b]), .hi_oe(bus_hi_oe[b]),
            .strobe_n(bus_stb_n[b]), .capture(bus_cap[b])
        );
    end

    // Maps the per-bus signals onto the named pins.
    always_comb begin
        ale          = |bus_ale;
        pri_ad_out   = bus_lo_out[BUS_PRI];
        pri_ad_oe    = bus_lo_oe[BUS_PRI];
        pri_hi_out   = bus_hi_out[BUS_PRI];
        pri_hi_oe    = bus_hi_oe[BUS_PRI];
        pri_strobe_n = bus_stb_n[BUS_PRI];
        aux_lo_out   = bus_lo_out[BUS_AUX];
        aux_lo_oe    = bus_lo_oe[BUS_AUX];
        aux_hi_out   = bus_hi_out[BUS_AUX];
        aux_hi_oe    = bus_hi_oe[BUS_AUX];
        aux_strobe_n = bus_stb_n[BUS_AUX];
    end

    // Stores the read byte as the strobe rises and pulses valid once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode       <= 8'h00;
            opcode_valid <= 1'b0;
        end else begin
            opcode_valid <= |bus_cap;
            if (bus_cap[BUS_AUX]) begin
                opcode <= aux_lo_in;
            end else if (bus_cap[BUS_PRI]) begin
                opcode <= pri_ad_in;
            end
        end
    end

    a_r3_one_strobe_at_most: assert property (@(posedge clk) disable iff (!rst_n)
        pri_strobe_n || aux_strobe_n);
    a_r2_ale_not_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (pri_strobe_n && aux_strobe_n));
    a_r4_invalid_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mode_invalid |-> (!ale && pri_strobe_n && aux_strobe_n && !pri_ad_oe && !aux_lo_oe));
    a_r10_aux_off_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_enabled |-> (!aux_lo_oe && !aux_hi_oe && aux_strobe_n));
    a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode_valid && $past(rst_n)) |-> !($past(pri_strobe_n) && $past(aux_strobe_n)));
    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        opcode_valid |=> !opcode_valid);
    a_r7_lo_released_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_ad_oe && !pri_strobe_n) && !(aux_lo_oe && !aux_strobe_n));

endmodule

// File: tb/fetch_steer_top_tb_top.sv
// Bench: random and directed fetch traffic in all four modes, checked each
// clock against a cycle model written from the requirements.
module fetch_steer_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel_pin = 1'b0;
    logic        ext_fetch_pin = 1'b0;
    logic [15:0] fetch_addr = 16'h0;
    logic        xdata_pending = 1'b0;
    logic [7:0]  pri_ad_in = 8'h0;
    logic [7:0]  aux_lo_in = 8'h0;
    logic        ale, pri_ad_oe, pri_hi_oe, pri_strobe_n;
    logic        aux_lo_oe, aux_hi_oe, aux_strobe_n, opcode_valid, mode_invalid;
    logic [7:0]  pri_ad_out, pri_hi_out, aux_lo_out, aux_hi_out, opcode;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    fetch_steer_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_pin(bus_sel_pin),
        .ext_fetch_pin(ext_fetch_pin), .fetch_addr(fetch_addr),
        .xdata_pending(xdata_pending), .pri_ad_in(pri_ad_in),
        .aux_lo_in(aux_lo_in), .ale(ale), .pri_ad_out(pri_ad_out),
        .pri_ad_oe(pri_ad_oe), .pri_hi_out(pri_hi_out), .pri_hi_oe(pri_hi_oe),
        .pri_strobe_n(pri_strobe_n), .aux_lo_out(aux_lo_out),
        .aux_lo_oe(aux_lo_oe), .aux_hi_out(aux_hi_out), .aux_hi_oe(aux_hi_oe),
        .aux_strobe_n(aux_strobe_n), .opcode(opcode),
        .opcode_valid(opcode_valid), .mode_invalid(mode_invalid)
    );

    // Model state.
    int          m_tick = 11;
    bit          m_live = 0, m_aux = 0, m_skip = 0, m_valid = 0, m_in_reset = 1;
    logic [15:0] m_addr = 0;
    logic [7:0]  m_op = 0;
    bit          m_bsel = 0, m_ext = 0;

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string mode_tag();
        if (m_in_reset) return "R1";
        case ({m_bsel, m_ext})
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Compares every output with the model's expectation for this clock.
    task automatic check_outputs();
        int  p = (m_tick >= 6) ? m_tick - 6 : m_tick;
        bit  ps = m_live && !m_aux;
        bit  as = m_live && m_aux;
        bit  ps_lo = ps && p < 3;
        bit  as_lo = as && p < 3;
        string st = (m_skip && m_tick >= 6) ? "R8" : mode_tag();
        string at = m_in_reset ? "R1" : (!m_bsel ? "R10" : "R7");
        chk(m_in_reset ? "R1" : "R2", "ale", 16'(ale), 16'(m_live && p < 2));
        chk(st, "pri_strobe_n", 16'(pri_strobe_n), 16'(!(ps && p >= 3 && p <= 4)));
        chk(st, "aux_strobe_n", 16'(aux_strobe_n), 16'(!(as && p >= 3 && p <= 4)));
        chk(m_in_reset ? "R1" : "R7", "pri_lo", {7'(0), pri_ad_oe, pri_ad_out},
            {7'(0), ps_lo, ps_lo ? m_addr[7:0] : 8'h00});
        chk(m_in_reset ? "R1" : "R7", "pri_hi", {7'(0), pri_hi_oe, pri_hi_out},
            {7'(0), ps, ps ? m_addr[15:8] : 8'h00});
        chk(at, "aux_lo", {7'(0), aux_lo_oe, aux_lo_out},
            {7'(0), as_lo, as_lo ? m_addr[7:0] : 8'h00});
        chk(at, "aux_hi", {7'(0), aux_hi_oe, aux_hi_out},
            {7'(0), as, as ? m_addr[15:8] : 8'h00});
        chk(m_in_reset ? "R1" : "R9", "opcode_valid", 16'(opcode_valid), 16'(m_valid));
        if (!m_in_reset) begin
            chk("R9", "opcode", 16'(opcode), 16'(m_op));
            chk("R11", "mode_invalid", 16'(mode_invalid), 16'(m_bsel == 0 && m_ext == 1));
        end
    endtask

    // Advances the model by one rising edge using the inputs now driven.
    task automatic step_model();
        int p = (m_tick >= 6) ? m_tick - 6 : m_tick;
        if (!rst_n) begin
            m_tick = 11; m_live = 0; m_aux = 0; m_addr = 0; m_valid = 0;
            m_op = 0; m_skip = 0; m_in_reset = 1;
            m_bsel = bus_sel_pin; m_ext = ext_fetch_pin;
            return;
        end
        m_in_reset = 0;
        m_valid = m_live && p == 4;
        if (m_valid) m_op = m_aux ? aux_lo_in : pri_ad_in;
        if (p == 5) begin
            m_addr = fetch_addr;
            m_aux  = (m_bsel && !m_ext) || (m_bsel && m_ext && fetch_addr < 16'h2000);
            m_skip = (m_tick == 5) && xdata_pending;
            m_live = !(!m_bsel && m_ext) && !m_skip;
        end
        m_tick = (m_tick == 11) ? 0 : m_tick + 1;
    endtask

    function automatic logic [15:0] pick_addr();
        case ($urandom_range(0, 7))
            0: return 16'h0000;
            1: return 16'h1FFF;
            2: return 16'h2000;
            3: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    // One clock: check, drive fresh inputs, predict the next edge.
    task automatic cycle(bit noisy_pins);
        @(negedge clk);
        check_outputs();
        fetch_addr    = pick_addr();
        xdata_pending = ($urandom_range(0, 2) == 0);
        pri_ad_in     = 8'($urandom);
        aux_lo_in     = 8'($urandom);
        if (noisy_pins) begin
            bus_sel_pin   = 1'($urandom);
            ext_fetch_pin = 1'($urandom);
        end
        step_model();
    endtask

    task automatic run_mode(bit bs, bit ex, int n);
        @(negedge clk);
        rst_n = 1'b0;
        bus_sel_pin = bs; ext_fetch_pin = ex;
        step_model();
        for (int i = 0; i < 3; i++) cycle(0);
        @(negedge clk);
        check_outputs();
        rst_n = 1'b1;
        step_model();
        // R11: pins wander after release; routing must follow the latched mode.
        for (int i = 0; i < n; i++) cycle(i > 24);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        step_model();
        for (int m = 0; m < 4; m++) begin
            run_mode(m[1], m[0], 600);
            run_mode(m[1], m[0], 300);
        end
        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule